// File: doc/BRIEF.md
# Early-Out Variable-Latency Comparator

This block compares two unsigned operands. It reports whether they are equal and whether the first is below the second. Its completion time depends on the data. On an accepted start, a narrow probe checks only the least significant bits of the two operands. If those bits disagree, the operands cannot be equal. The block then finishes after a single cycle with equality cleared. If the probe bits match, the block captures the operands and finishes through the full-width path a fixed number of cycles later.

A small result multiplexer picks which path's answer goes to the registered outputs. The unsigned less-than flag is computed at full width on both paths, so it is valid at every completion. The block fits loops that compare small-stride counters or tags, where most mismatches show up in the low bits.

The block handles one comparison at a time. A start that arrives while a full-width compare is pending is dropped. Completion is signalled by a one-cycle done pulse. The results stay unchanged until the next completion.

Top module: `early_cmp`

## Requirements
- R1: After reset, done_o, eq_o and lt_o are all 0.
- R2: If start_i is accepted and bits [3:0] of a_i and b_i differ, done_o is 1 in the cycle right after the accepting clock edge, and eq_o is 0 there.
- R3: If start_i is accepted and bits [3:0] of a_i and b_i match, done_o is 1 exactly FULL_LAT cycles after the accepting edge (default 3), and eq_o is 1 exactly when all 32 bits match.
- R4: lt_o at every completion equals the unsigned comparison a < b of the accepted operands, on both the single-cycle path and the full-width path.
- R5: done_o is high for exactly one cycle per accepted compare. It stays 0 in every cycle that does not end a compare.
- R6: eq_o and lt_o change only in a completion cycle and otherwise hold their last values.
- R7: start_i is accepted only when no full-width compare is pending. Starts during one are ignored, including at the edge where it completes. Changes on a_i or b_i after acceptance do not affect the result.
- R8: Equal operands always take the full FULL_LAT latency.
- R9: After a single-cycle compare, a new start is accepted at the very next edge, so fast compares can complete in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a compare of a_i and b_i |
| a_i | input | 32 | First operand (unsigned) |
| b_i | input | 32 | Second operand (unsigned) |
| done_o | output | 1 | One-cycle completion pulse |
| eq_o | output | 1 | Operands equal, held until next completion |
| lt_o | output | 1 | a below b (unsigned), held until next completion |

## Verification
The assertions assume that start_i, a_i and b_i are stable around the rising edge. They also assume that reset is held for at least one edge before any request. The bench drives every input on the falling edge and releases reset before its first request.

The probe decision and timer state are brought out as named internal events. This lets the checker tie the accept decision to the cycle of completion. Nothing is assumed about start spacing, since the block must drop requests on its own. The bench deliberately holds start_i high across a pending compare and changes the operands mid-compare.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Which computation supplies the registered result
  typedef enum logic {
    PATH_FAST = 1'b0,
    PATH_FULL = 1'b1
  } path_e;

  // Shortest full-width latency for which the probe path stays
  // below half of the full path (1 cycle versus FULL_LAT cycles)
  localparam int unsigned MIN_FULL_LAT = 3;
endpackage

// File: rtl/tc_probe.sv
module tc_probe #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PROBE_W = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              mismatch
);
  function automatic logic low_bits_differ(input logic [DATA_W-1:0] x,
                                           input logic [DATA_W-1:0] y);
    logic [PROBE_W-1:0] diff;
    diff = x[PROBE_W-1:0] ^ y[PROBE_W-1:0];
    return |diff;
  endfunction

  assign mismatch = low_bits_differ(a, b);
endmodule

// File: rtl/tc_magnitude.sv
module tc_magnitude #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              eq,
  output logic              lt
);
  function automatic logic all_bits_equal(input logic [DATA_W-1:0] x,
                                          input logic [DATA_W-1:0] y);
    return ~|(x ^ y);
  endfunction

  // Unsigned below: borrow out of x - y
  function automatic logic unsigned_below(input logic [DATA_W-1:0] x,
                                          input logic [DATA_W-1:0] y);
    logic [DATA_W:0] d;
    d = {1'b0, x} - {1'b0, y};
    return d[DATA_W];
  endfunction

  assign eq = all_bits_equal(a, b);
  assign lt = unsigned_below(a, b);
endmodule

// File: rtl/tc_timer.sv
module tc_timer #(
  parameter int unsigned FULL_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic fire
);
  localparam int unsigned CNT_W = $clog2(FULL_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= CNT_W'(FULL_LAT - 1);
    else if (busy)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tc_resmux.sv
module tc_resmux
  import tc_pkg::*;
(
  input  path_e sel,
  input  logic  fast_eq,
  input  logic  fast_lt,
  input  logic  full_eq,
  input  logic  full_lt,
  output logic  eq,
  output logic  lt
);
  always_comb begin
    if (sel == PATH_FULL) begin
      eq = full_eq;
      lt = full_lt;
    end else begin
      eq = fast_eq;
      lt = fast_lt;
    end
  end
endmodule

// File: rtl/early_cmp.sv
module early_cmp
  import tc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROBE_W  = 4,
  parameter int unsigned FULL_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              done_o,
  output logic              eq_o,
  output logic              lt_o
);
  generate
    if (FULL_LAT < MIN_FULL_LAT || PROBE_W == 0 || PROBE_W >= DATA_W) begin : g_bad_cfg
      $error("early_cmp: unsupported parameter combination");
    end
  endgenerate

  // Named internal events
  logic accept;      // start taken this edge
  logic early_hit;   // probe bits disagree on live operands
  logic busy;        // full-width compare pending
  logic full_fire;   // full-width compare completes this edge
  logic finish;      // any completion this edge

  logic [DATA_W-1:0] a_q, b_q;
  logic fast_eq, fast_lt, full_eq, full_lt, sel_eq, sel_lt;
  path_e sel;

  tc_probe #(.DATA_W(DATA_W), .PROBE_W(PROBE_W)) u_probe (
    .a(a_i), .b(b_i), .mismatch(early_hit)
  );

  tc_timer #(.FULL_LAT(FULL_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept && !early_hit),
    .busy(busy), .fire(full_fire)
  );

  // Live operands feed the fast answer, captured ones the full answer
  tc_magnitude #(.DATA_W(DATA_W)) u_mag_fast (
    .a(a_i), .b(b_i), .eq(fast_eq), .lt(fast_lt)
  );

  tc_magnitude #(.DATA_W(DATA_W)) u_mag_full (
    .a(a_q), .b(b_q), .eq(full_eq), .lt(full_lt)
  );

  assign accept = start_i && !busy;
  assign finish = (accept && early_hit) || full_fire;
  assign sel    = full_fire ? PATH_FULL : PATH_FAST;

  tc_resmux u_mux (
    .sel(sel), .fast_eq(fast_eq), .fast_lt(fast_lt),
    .full_eq(full_eq), .full_lt(full_lt), .eq(sel_eq), .lt(sel_lt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept && !early_hit) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      eq_o   <= 1'b0;
      lt_o   <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        eq_o <= sel_eq;
        lt_o <= sel_lt;
      end
    end
  end
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned FULL_LAT = 3
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic early_hit,
  input logic busy,
  input logic full_fire,
  input logic done_o,
  input logic eq_o,
  input logic lt_o
);
  localparam int unsigned CW = $clog2(FULL_LAT + 1);

  // Busy cycles seen before the current completion
  logic [CW-1:0] wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wait_q <= '0;
    else if (full_fire)          wait_q <= '0;
    else if (busy)               wait_q <= wait_q + 1'b1;
  end

  // R2: probe mismatch completes on the next cycle as not-equal
  a_r2_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept && early_hit |=> done_o && !eq_o);

  // R3: probe match starts the full-width wait
  a_r3_full_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !early_hit |=> busy);

  // R3: full-width completion only after the parameterised wait
  a_r3_full_latency: assert property (@(posedge clk) disable iff (!rst_n)
    full_fire |-> wait_q == CW'(FULL_LAT - 2));

  // R5 and R6: no completion edge means no pulse and held results
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && early_hit) && !full_fire |=> !done_o && $stable(eq_o) && $stable(lt_o));

  // R7: no request is taken while a full-width compare is pending
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R8: an equal result only ever comes from the full-width path
  a_r8_eq_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && eq_o |-> $past(full_fire));
endmodule

bind early_cmp tc_checker #(.FULL_LAT(FULL_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .early_hit(early_hit),
  .busy(busy), .full_fire(full_fire), .done_o(done_o),
  .eq_o(eq_o), .lt_o(lt_o)
);

// File: tb/early_cmp_tb.sv
`timescale 1ns/1ps
module early_cmp_tb;
  localparam int FULL_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic done_o, eq_o, lt_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  early_cmp #(.DATA_W(32), .PROBE_W(4), .FULL_LAT(FULL_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .done_o(done_o), .eq_o(eq_o), .lt_o(lt_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  // Full compare with a one-cycle start; checks latency, results, single pulse
  task automatic run_cmp(input logic [31:0] a, input logic [31:0] b, input string req);
    int lat;
    int seen;
    lat = (a[3:0] != b[3:0]) ? 1 : FULL_LAT;
    seen = 0;
    @(negedge clk);
    a_i = a; b_i = b; start_i = 1'b1;
    for (int i = 1; i <= FULL_LAT + 1; i++) begin
      sample();
      if (i == 1) begin
        @(negedge clk);
        start_i = 1'b0;
        a_i = ~a; b_i = b + 32'd7;   // operands move after acceptance (R7)
        #1.5;
      end
      if (i == lat) begin
        chk(done_o === 1'b1, req, "done at latency", done_o, 1);
        chk(eq_o === (a == b), req, "eq", eq_o, a == b);
        chk(lt_o === (a < b), "R4", "lt", lt_o, a < b);
        seen = 1;
      end else begin
        chk(done_o === 1'b0, "R5", "done outside completion", done_o, 0);
      end
    end
    chk(seen == 1, req, "completion seen", seen, 1);
  endtask

  task automatic t_reset();
    chk(done_o === 1'b0, "R1", "done after reset", done_o, 0);
    chk(eq_o === 1'b0, "R1", "eq after reset", eq_o, 0);
    chk(lt_o === 1'b0, "R1", "lt after reset", lt_o, 0);
  endtask

  task automatic t_fast();
    run_cmp(32'h0000_0001, 32'h0000_0002, "R2");
    run_cmp(32'hFFFF_FFF0, 32'h0000_0003, "R2");
    run_cmp(32'h1234_5678, 32'h1234_5679, "R2");
    run_cmp(32'h8000_000F, 32'h8000_000E, "R2");
  endtask

  task automatic t_full();
    run_cmp(32'h0000_0015, 32'h0000_0005, "R3");
    run_cmp(32'h7FFF_FFF3, 32'h8000_0003, "R3");
    run_cmp(32'hA000_0000, 32'h0000_0000, "R3");
  endtask

  task automatic t_equal();
    run_cmp(32'h0000_0000, 32'h0000_0000, "R8");
    run_cmp(32'hDEAD_BEEF, 32'hDEAD_BEEF, "R8");
    run_cmp(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
  endtask

  // Start held high over a pending compare with fast-mismatching operands
  task automatic t_busy_ignore();
    @(negedge clk);
    a_i = 32'h0000_0040; b_i = 32'h0000_0040; start_i = 1'b1;
    for (int i = 1; i <= FULL_LAT + 1; i++) begin
      sample();
      if (i == FULL_LAT) begin
        chk(done_o === 1'b1, "R7", "done of held-start compare", done_o, 1);
        chk(eq_o === 1'b1, "R7", "eq of first operands", eq_o, 1);
        chk(lt_o === 1'b0, "R7", "lt of first operands", lt_o, 0);
      end else begin
        chk(done_o === 1'b0, "R7", "no done from ignored start", done_o, 0);
      end
      @(negedge clk);
      if (i == 1) begin a_i = 32'h0000_0001; b_i = 32'h0000_0002; end
      if (i == FULL_LAT - 1) start_i = 1'b0;
    end
  endtask

  task automatic t_hold();
    run_cmp(32'h0000_0003, 32'h0000_0009, "R6");
    @(negedge clk);
    a_i = 32'hFFFF_FFFF; b_i = 32'h0;
    for (int i = 0; i < 4; i++) begin
      sample();
      chk(done_o === 1'b0, "R5", "idle done", done_o, 0);
      chk(eq_o === 1'b0 && lt_o === 1'b1, "R6", "held results",
          {eq_o, lt_o}, 2'b01);
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    a_i = 32'h0000_0001; b_i = 32'h0000_0000; start_i = 1'b1;
    sample();
    chk(done_o === 1'b1 && lt_o === 1'b0, "R9", "first fast done",
        {done_o, lt_o}, 2'b10);
    @(negedge clk);
    a_i = 32'h0000_0000; b_i = 32'h0000_0001;
    sample();
    chk(done_o === 1'b1 && lt_o === 1'b1, "R9", "second fast done",
        {done_o, lt_o}, 2'b11);
    @(negedge clk);
    start_i = 1'b0;
    sample();
    chk(done_o === 1'b0, "R9", "no third done", done_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    sample();
    t_reset();
    t_fast();
    t_full();
    t_equal();
    t_busy_ignore();
    t_hold();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule